// File: doc/BRIEF.md
# Sector Write Protection Checker

This block decides, cycle by cycle, whether a program or erase request aimed at a word address of a 2M-word flash array may go ahead. It decodes the 21-bit target address into one of 71 sectors and one of two banks. The layout is top-boot: the upper 32K words are split into eight 4K-word boot sectors and the rest of the array is cut into 32K-word sectors. Bank B is the lower three quarters of the array and bank A is the upper quarter, which includes the boot sectors.

Each sector has one lock bit. A lock command strobe, decoded elsewhere, sets or clears the bit of the sector that the target address selects. The write-allowed output combines that bit with four other conditions. The hardware write-protect pin guards the two topmost boot sectors. A level on the acceleration pin locks the whole array. A supply-lockout flag blocks every write and freezes the lock bits. Write qualification on the bus control pins must also hold. A second address port takes the current read address and reports a conflict when it lands in the bank that is marked busy with a program or erase. This lets the host route reads to the other bank while one bank is busy.

All outputs except the lock bits are combinational, so they follow the present inputs. A lock command changes the lock state from the next cycle on.

Top module: `sector_guard`

## Requirements
- R1: `sectorIdx` is `wrAddr[20:15]` for addresses below 0x1F8000, and 63 + `wrAddr[14:12]` for addresses from 0x1F8000 to 0x1FFFFF, which gives the range 0 to 70. Sector 70 is the highest 4K-word sector.
- R2: `bankA` is 1 for addresses 0x180000 and above (sectors 48 to 70) and 0 below (bank B, sectors 0 to 47).
- R3: `writeOk` is 0 whenever the lock bit of the addressed sector is set.
- R4: A cycle with `lockCmd`=1 and `lockVal`=1 sets the lock bit of the sector that `wrAddr` selects. `writeOk` for that sector changes from the following cycle, not in the command cycle, and every other sector keeps its lock state.
- R5: A cycle with `lockCmd`=1 and `lockVal`=0 clears the lock bit of the addressed sector from the following cycle.
- R6: While `wpN`=0, `writeOk` is 0 for sectors 69 and 70, and sectors 0 to 68 are not affected.
- R7: While `allLock`=1, `writeOk` is 0 for every sector.
- R8: While `vccLow`=1, `writeOk` is 0 and `lockCmd` has no effect on any lock bit.
- R9: `writeOk` can be 1 only when `ceN`=0, `weN`=0 and `oeN`=1.
- R10: Reset (`rst_n`=0) clears every lock bit.
- R11: `rdConflict` = `busyValid` AND (bank of `rdAddr` equals `busyBankA`), where the bank uses the same encoding as in R2 (1 = bank A).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears the lock bits |
| wrAddr | input | 21 | Word address targeted by program, erase or lock command |
| rdAddr | input | 21 | Word address of the current read |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| wpN | input | 1 | Write-protect pin, low guards sectors 69 and 70 |
| allLock | input | 1 | High when the acceleration pin sits at its locking level |
| vccLow | input | 1 | High while the supply is below the lockout threshold |
| lockCmd | input | 1 | Lock/unlock command strobe |
| lockVal | input | 1 | 1 = lock, 0 = unlock, used with lockCmd |
| busyValid | input | 1 | A program or erase is in progress |
| busyBankA | input | 1 | Bank of the operation in progress, 1 = bank A |
| sectorIdx | output | 7 | Sector of wrAddr |
| bankA | output | 1 | Bank of wrAddr, 1 = bank A |
| writeOk | output | 1 | Program or erase to wrAddr is permitted |
| rdConflict | output | 1 | rdAddr lies in the busy bank |

## Verification
A lock or unlock command and a qualified write check on the same sector can fall in the same cycle. A lock command can also arrive in the same cycle as a supply lockout. The bench provokes the first case by holding write qualification on while it issues the command. It expects `writeOk` to show the old lock state in that cycle and the new state in the next one. For the second case it issues a lock command under `vccLow` and then shows, once the lockout is released, that the sector is still writable. A behavioural model with its own address arithmetic also runs alongside a long random stretch of mixed commands, pin levels and read addresses, and it compares all four outputs on every clock.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int ADDR_W    = 21;
  localparam int BIG_LOG   = 15;
  localparam int SMALL_LOG = 12;
  localparam int NUM_BIG   = 63;
  localparam int NUM_SMALL = 1 << (BIG_LOG - SMALL_LOG);
  localparam int NUM_SECT  = NUM_BIG + NUM_SMALL;
  localparam int SECT_W    = $clog2(NUM_SECT);
  localparam int BANKB_CNT = 48;
  localparam int OUTER_CNT = 2;

  typedef logic [SECT_W-1:0] sect_t;

  typedef struct packed {
    logic lockSet;
    logic lockClr;
  } lockStrb_t;

  function automatic sect_t sectOf(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-BIG_LOG-1:0]   bigIdx;
    logic [BIG_LOG-SMALL_LOG-1:0] subIdx;
    bigIdx = a[ADDR_W-1:BIG_LOG];
    subIdx = a[BIG_LOG-1:SMALL_LOG];
    if (int'(bigIdx) < NUM_BIG) return sect_t'(bigIdx);
    else return sect_t'(NUM_BIG + int'(subIdx));
  endfunction

  function automatic logic inBankA(input sect_t s);
    return int'(s) >= BANKB_CNT;
  endfunction
endpackage

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  lockStrb_t         strb,
  output sect_t             sectorIdx,
  output logic              wrBankA,
  output logic              rdBankA,
  output logic              sectLocked,
  output logic              outerBoot
);
  logic [NUM_SECT-1:0] lockBits;
  logic [NUM_SECT-1:0] lockNext;
  sect_t               rdSect;

  assign sectorIdx  = sectOf(wrAddr);
  assign rdSect     = sectOf(rdAddr);
  assign wrBankA    = inBankA(sectorIdx);
  assign rdBankA    = inBankA(rdSect);
  assign sectLocked = lockBits[sectorIdx];
  assign outerBoot  = int'(sectorIdx) >= (NUM_SECT - OUTER_CNT);

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_lock
    logic hit;
    assign hit = (sectorIdx == SECT_W'(s));
    assign lockNext[s] = hit ? (strb.lockSet | (lockBits[s] & ~strb.lockClr))
                             : lockBits[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lockBits <= '0;
    else        lockBits <= lockNext;
  end

  // R4
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.lockSet |=> lockBits[$past(sectorIdx)]);

  // R5
  lock_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.lockClr && !strb.lockSet) |=> !lockBits[$past(sectorIdx)]);

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.lockSet && !strb.lockClr) |=> $stable(lockBits));

  // R1
  sect_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sectorIdx) < NUM_SECT);
endmodule

// File: rtl/sg_control.sv
module sg_control
  import sg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ceN,
  input  logic      weN,
  input  logic      oeN,
  input  logic      wpN,
  input  logic      allLock,
  input  logic      vccLow,
  input  logic      lockCmd,
  input  logic      lockVal,
  input  logic      busyValid,
  input  logic      busyBankA,
  input  logic      sectLocked,
  input  logic      outerBoot,
  input  logic      rdBankA,
  output lockStrb_t strb,
  output logic      writeOk,
  output logic      rdConflict
);
  logic busWrite;
  logic hwBlock;
  logic cmdLive;

  assign busWrite = !ceN && !weN && oeN;
  assign hwBlock  = allLock || vccLow || (outerBoot && !wpN);
  assign writeOk  = busWrite && !hwBlock && !sectLocked;

  assign cmdLive      = lockCmd && !vccLow;
  assign strb.lockSet = cmdLive && lockVal;
  assign strb.lockClr = cmdLive && !lockVal;

  assign rdConflict = busyValid && (rdBankA == busyBankA);

  // R3
  locked_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sectLocked |-> !writeOk);

  // R6
  wp_outer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wpN && outerBoot) |-> !writeOk);

  // R9
  bus_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    writeOk |-> (!ceN && !weN && oeN));

  // R8
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vccLow |-> (!writeOk && !strb.lockSet && !strb.lockClr));

  // R11
  conflict_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busyValid |-> !rdConflict);
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              wpN,
  input  logic              allLock,
  input  logic              vccLow,
  input  logic              lockCmd,
  input  logic              lockVal,
  input  logic              busyValid,
  input  logic              busyBankA,
  output logic [SECT_W-1:0] sectorIdx,
  output logic              bankA,
  output logic              writeOk,
  output logic              rdConflict
);
  lockStrb_t strb;
  logic      sectLocked;
  logic      outerBoot;
  logic      rdBankA;

  sg_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrAddr     (wrAddr),
    .rdAddr     (rdAddr),
    .strb       (strb),
    .sectorIdx  (sectorIdx),
    .wrBankA    (bankA),
    .rdBankA    (rdBankA),
    .sectLocked (sectLocked),
    .outerBoot  (outerBoot)
  );

  sg_control u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ceN        (ceN),
    .weN        (weN),
    .oeN        (oeN),
    .wpN        (wpN),
    .allLock    (allLock),
    .vccLow     (vccLow),
    .lockCmd    (lockCmd),
    .lockVal    (lockVal),
    .busyValid  (busyValid),
    .busyBankA  (busyBankA),
    .sectLocked (sectLocked),
    .outerBoot  (outerBoot),
    .rdBankA    (rdBankA),
    .strb       (strb),
    .writeOk    (writeOk),
    .rdConflict (rdConflict)
  );
endmodule

// File: tb/sector_guard_tb.sv
`timescale 1ns/100ps
module sector_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] wrAddr = '0;
  logic [20:0] rdAddr = '0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, wpN = 1'b1;
  logic allLock = 1'b0, vccLow = 1'b0, lockCmd = 1'b0, lockVal = 1'b0;
  logic busyValid = 1'b0, busyBankA = 1'b0;
  logic [6:0]  sectorIdx;
  logic        bankA, writeOk, rdConflict;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  bit refLock [0:70];

  always #2 clk = ~clk;

  sector_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .ceN(ceN), .weN(weN), .oeN(oeN), .wpN(wpN), .allLock(allLock),
    .vccLow(vccLow), .lockCmd(lockCmd), .lockVal(lockVal),
    .busyValid(busyValid), .busyBankA(busyBankA),
    .sectorIdx(sectorIdx), .bankA(bankA), .writeOk(writeOk),
    .rdConflict(rdConflict)
  );

  function automatic int refSect(int a);
    if (a < 'h1F8000) return a / 32768;
    return 63 + (a - 'h1F8000) / 4096;
  endfunction

  function automatic int refBankA(int a);
    return (a >= 'h180000) ? 1 : 0;
  endfunction

  function automatic int refOk();
    int s;
    s = refSect(int'(wrAddr));
    if (!(ceN == 0 && weN == 0 && oeN == 1)) return 0;
    if (vccLow || allLock) return 0;
    if (wpN == 0 && s >= 69) return 0;
    if (refLock[s]) return 0;
    return 1;
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural lock model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 71; i++) refLock[i] <= 1'b0;
    end else if (lockCmd && !vccLow) begin
      refLock[refSect(int'(wrAddr))] <= lockVal;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(sectorIdx), refSect(int'(wrAddr)), "R1 model sector");
      chk(int'(bankA), refBankA(int'(wrAddr)), "R2 model bank");
      chk(int'(writeOk), refOk(), "R3 model writeOk");
      chk(int'(rdConflict),
          (busyValid && (refBankA(int'(rdAddr)) == int'(busyBankA))) ? 1 : 0,
          "R11 model conflict");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  task automatic qualWrite(logic [20:0] a);
    wrAddr = a; ceN = 0; weN = 0; oeN = 1;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    sample();
    chk(int'(writeOk), 0, "R9 idle bus after reset");

    // reset state: every sector writable
    for (int s = 0; s < 71; s++) begin
      tick();
      qualWrite((s < 63) ? 21'(s * 32768) : 21'('h1F8000 + (s - 63) * 4096));
      sample();
      chk(int'(writeOk), 1, "R10 unlocked after reset");
    end

    // sector boundaries
    tick(); wrAddr = 21'h000000; sample(); chk(int'(sectorIdx), 0, "R1 addr 0");
    tick(); wrAddr = 21'h1F7FFF; sample(); chk(int'(sectorIdx), 62, "R1 last big");
    tick(); wrAddr = 21'h1F8000; sample(); chk(int'(sectorIdx), 63, "R1 first boot");
    tick(); wrAddr = 21'h1FFFFF; sample(); chk(int'(sectorIdx), 70, "R1 top boot");
    tick(); wrAddr = 21'h17FFFF; sample(); chk(int'(bankA), 0, "R2 below split");
    tick(); wrAddr = 21'h180000; sample(); chk(int'(bankA), 1, "R2 at split");

    // lock sector 5 while qualified write is present
    tick(); qualWrite(21'h028000); lockCmd = 1; lockVal = 1;
    sample(); chk(int'(writeOk), 1, "R4 old state in command cycle");
    tick(); lockCmd = 0;
    sample(); chk(int'(writeOk), 0, "R4 locked next cycle");
    tick(); wrAddr = 21'h030000;
    sample(); chk(int'(writeOk), 1, "R4 neighbour untouched");
    tick(); wrAddr = 21'h02ABCD;
    sample(); chk(int'(writeOk), 0, "R3 locked inside sector");
    tick(); lockCmd = 1; lockVal = 0;
    sample(); chk(int'(writeOk), 0, "R5 still locked in command cycle");
    tick(); lockCmd = 0;
    sample(); chk(int'(writeOk), 1, "R5 unlocked next cycle");

    // write-protect pin
    tick(); wpN = 0; qualWrite(21'h1FF000);
    sample(); chk(int'(writeOk), 0, "R6 sector 70 guarded");
    tick(); wrAddr = 21'h1FE000;
    sample(); chk(int'(writeOk), 0, "R6 sector 69 guarded");
    tick(); wrAddr = 21'h1FD000;
    sample(); chk(int'(writeOk), 1, "R6 sector 68 free");
    tick(); wpN = 1; wrAddr = 21'h1FF000;
    sample(); chk(int'(writeOk), 1, "R6 released");

    // all-lock level
    tick(); allLock = 1; wrAddr = 21'h000000;
    sample(); chk(int'(writeOk), 0, "R7 sector 0 locked");
    tick(); wrAddr = 21'h1C0000;
    sample(); chk(int'(writeOk), 0, "R7 bank A locked");
    tick(); allLock = 0;

    // supply lockout with a coincident lock command
    tick(); vccLow = 1; wrAddr = 21'h050000; lockCmd = 1; lockVal = 1;
    sample(); chk(int'(writeOk), 0, "R8 lockout blocks write");
    tick(); lockCmd = 0;
    tick(); vccLow = 0;
    sample(); chk(int'(writeOk), 1, "R8 lock command ignored");

    // bus qualification
    tick(); oeN = 0; sample(); chk(int'(writeOk), 0, "R9 oeN low");
    tick(); oeN = 1; weN = 1; sample(); chk(int'(writeOk), 0, "R9 weN high");
    tick(); weN = 0; ceN = 1; sample(); chk(int'(writeOk), 0, "R9 ceN high");
    tick(); ceN = 0; sample(); chk(int'(writeOk), 1, "R9 qualified");

    // reset clears locks
    tick(); wrAddr = 21'h0A0000; lockCmd = 1; lockVal = 1;
    tick(); lockCmd = 0;
    sample(); chk(int'(writeOk), 0, "R4 sector 20 locked");
    rst_n = 0;
    tick(); rst_n = 1;
    tick();
    sample(); chk(int'(writeOk), 1, "R10 reset clears lock");

    // read conflict
    tick(); busyValid = 1; busyBankA = 1; rdAddr = 21'h180000;
    sample(); chk(int'(rdConflict), 1, "R11 read in busy bank A");
    tick(); rdAddr = 21'h17FFFF;
    sample(); chk(int'(rdConflict), 0, "R11 read in bank B");
    tick(); busyBankA = 0;
    sample(); chk(int'(rdConflict), 1, "R11 read in busy bank B");
    tick(); busyValid = 0;
    sample(); chk(int'(rdConflict), 0, "R11 nothing busy");

    // random stretch compared against the model every clock
    for (int n = 0; n < 3000; n++) begin
      tick();
      wrAddr    = ($urandom_range(0, 3) == 0) ? 21'($urandom_range('h1F8000, 'h1FFFFF))
                                              : 21'($urandom_range(0, 'h1FFFFF));
      rdAddr    = 21'($urandom_range(0, 'h1FFFFF));
      ceN       = ($urandom_range(0, 7) == 0);
      weN       = ($urandom_range(0, 7) == 0);
      oeN       = ($urandom_range(0, 7) != 0);
      wpN       = ($urandom_range(0, 3) != 0);
      allLock   = ($urandom_range(0, 15) == 0);
      vccLow    = ($urandom_range(0, 15) == 0);
      lockCmd   = ($urandom_range(0, 2) == 0);
      lockVal   = ($urandom_range(0, 1) == 1);
      busyValid = ($urandom_range(0, 1) == 1);
      busyBankA = ($urandom_range(0, 1) == 1);
    end
    tick(); lockCmd = 0;
    sample();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule